// File: doc/BRIEF.md
# Stripe and Ramp Test Pattern Generator

This block sits in the digital back end of a two-channel image sensor front end, right before the output interleaver. It has one pixel strobe for both channels. On each strobe, every channel registers one 12-bit output word. While the test enable input is low, that word is the channel's normal conversion data. While the test enable input is high, the word comes from a built-in synthetic pattern, so the downstream path can be checked without an image on the sensor.

There are two patterns. The first is a stripe. It alternates between the channel's black level and the black level plus 128. The black level is twice the channel's 8-bit clamp code, so it spans 0 to 510. The second is a ramp. It starts at 1 and climbs by one code at a fixed pixel spacing up to full scale, then starts again at 1. A shared 2-bit interval code selects both the stripe width and the ramp spacing. Each channel keeps its own pattern state and uses its own black-level code. Lowering the test enable input returns both channels to their starting point.

Top module: `pgen_top`

## Requirements
- R1: While `rst` is high, `out_ev`, `out_od` and `out_vld` are all zero.
- R2: With `test_en` = 0, a cycle with `pix_stb` = 1 makes `out_vld` = 1 in the next cycle, and each channel output equals its `norm_*` input sampled at that strobe. `out_vld` is 0 in the cycle after any cycle without a strobe.
- R3: With `test_en` = 1 and `pat_sel` = 1 (stripe), a channel emits W strobes at the low level 2×code, then W strobes at the high level 2×code+128, and keeps alternating. W is 8, 16, 32 or 64 for `ivl_code` 0, 1, 2 or 3.
- R4: With `test_en` = 1 and `pat_sel` = 0 (ramp), a channel emits value 1 for S strobes, then 2 for S strobes, and so on. S is 2, 4, 8 or 16 for `ivl_code` 0, 1, 2 or 3.
- R5: After S strobes at value 4095, the ramp continues at 1. It never emits 0.
- R6: Every cycle with `test_en` = 0 returns both channels to the stripe low level and the ramp value 1 with a fresh span. The first strobe in a cycle where `test_en` is 1 again therefore emits the starting value.
- R7: The even channel uses only `blk_code_ev` and the odd channel uses only `blk_code_od`. Both channels advance in step on the shared strobe.
- R8: A cycle without `pix_stb` leaves both outputs unchanged and does not advance any pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | Pixel strobe, one pixel per channel per strobe |
| test_en | input | 1 | 1 = emit the test pattern, 0 = pass normal data |
| pat_sel | input | 1 | 0 = ramp, 1 = stripe |
| ivl_code | input | 2 | Shared stripe-width / ramp-spacing code |
| blk_code_ev | input | 8 | Even channel black-level code (level = 2×code) |
| blk_code_od | input | 8 | Odd channel black-level code (level = 2×code) |
| norm_ev | input | 12 | Even channel normal data |
| norm_od | input | 12 | Odd channel normal data |
| out_ev | output | 12 | Even channel output word |
| out_od | output | 12 | Odd channel output word |
| out_vld | output | 1 | Output words updated in the previous strobe cycle |

## Verification
Two events can fall in the same clock edge:
- the return to the starting state that follows a cycle with the test enable low, and
- the first pixel strobe after test mode is raised again.

The bench causes this by raising `test_en` in the same cycle as a strobe. It does so after a pattern was stopped partway through a span, and also after switching between stripe and ramp. It expects the very first emitted word to be the stripe low level or the ramp value 1, with a full span following. A second case of this kind is the ramp wrap, which always coincides with the end of a span. That case is provoked by running more than 8190 strobes at the shortest spacing, and it is judged against an independent scoreboard model.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    localparam int DATA_W      = 12;
    localparam int CODE_W      = 8;
    localparam int IVL_W       = 2;
    localparam int STRIPE_BASE = 8;
    localparam int RAMP_BASE   = 2;
    localparam int STRIPE_STEP = 128;
    localparam int N_CH        = 2;

    localparam int SPAN_MAX = STRIPE_BASE << ((1 << IVL_W) - 1);
    localparam int CNT_W    = $clog2(SPAN_MAX);
    localparam int RAMP_MAX = (1 << DATA_W) - 1;

    typedef enum logic {
        PAT_RAMP   = 1'b0,
        PAT_STRIPE = 1'b1
    } pat_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              hi;
        logic [DATA_W-1:0] ramp;
    } seq_t;

    localparam seq_t SEQ_INIT = '{cnt: '0, hi: 1'b0, ramp: DATA_W'(1)};

    // Index of the last pixel in one span for the chosen pattern and code.
    function automatic logic [CNT_W-1:0] span_last(input pat_e kind,
                                                   input logic [IVL_W-1:0] code);
        int unsigned base;
        base = (kind == PAT_STRIPE) ? STRIPE_BASE : RAMP_BASE;
        return CNT_W'((base << code) - 1);
    endfunction

    // Black level in output LSBs: two LSBs per code step.
    function automatic logic [DATA_W-1:0] clamp_base(input logic [CODE_W-1:0] code);
        return DATA_W'({code, 1'b0});
    endfunction

endpackage

// File: rtl/pgen_seq.sv
module pgen_seq
    import pgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              stb,
    input  logic              sel,
    input  logic [IVL_W-1:0]  ivl,
    input  logic [CODE_W-1:0] blk,
    output logic [DATA_W-1:0] pat_val
);

    pat_e kind;
    seq_t st_q, st_d;
    logic last;

    assign kind = pat_e'(sel);
    assign last = (st_q.cnt >= span_last(kind, ivl));

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = SEQ_INIT;
        end else if (stb) begin
            if (last) begin
                st_d.cnt = '0;
                if (kind == PAT_STRIPE) begin
                    st_d.hi = ~st_q.hi;
                end else begin
                    st_d.ramp = (st_q.ramp == DATA_W'(RAMP_MAX)) ? DATA_W'(1)
                                                                 : st_q.ramp + DATA_W'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SEQ_INIT;
        else     st_q <= st_d;
    end

    always_comb begin
        if (kind == PAT_STRIPE)
            pat_val = clamp_base(blk) + (st_q.hi ? DATA_W'(STRIPE_STEP) : DATA_W'(0));
        else
            pat_val = st_q.ramp;
    end

    // R5: ramp never shows zero
    p_ramp_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.ramp != '0);

    // R5: full-scale ramp at span end continues at one
    p_ramp_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (run && stb && kind == PAT_RAMP && last && st_q.ramp == DATA_W'(RAMP_MAX))
        |=> st_q.ramp == DATA_W'(1));

    // R3: stripe level flips at every span end
    p_stripe_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (run && stb && kind == PAT_STRIPE && last) |=> st_q.hi != $past(st_q.hi));

    // R6: a disabled cycle leaves the starting state
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (st_q.cnt == '0 && !st_q.hi && st_q.ramp == DATA_W'(1)));

    // R8: no strobe, no progress
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (run && !stb) |=> $stable(st_q));

endmodule

// File: rtl/pgen_sel.sv
module pgen_sel
    import pgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              test_en,
    input  logic [DATA_W-1:0] pat_val,
    input  logic [DATA_W-1:0] norm,
    output logic [DATA_W-1:0] out_q
);

    always_ff @(posedge clk) begin
        if (rst)      out_q <= '0;
        else if (stb) out_q <= test_en ? pat_val : norm;
    end

    // R8: output holds between strobes
    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(out_q));

    // R2: pass-through of normal data
    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (stb && !test_en) |=> out_q == $past(norm));

endmodule

// File: rtl/pgen_top.sv
module pgen_top
    import pgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_stb,
    input  logic              test_en,
    input  logic              pat_sel,
    input  logic [IVL_W-1:0]  ivl_code,
    input  logic [CODE_W-1:0] blk_code_ev,
    input  logic [CODE_W-1:0] blk_code_od,
    input  logic [DATA_W-1:0] norm_ev,
    input  logic [DATA_W-1:0] norm_od,
    output logic [DATA_W-1:0] out_ev,
    output logic [DATA_W-1:0] out_od,
    output logic              out_vld
);

    logic [CODE_W-1:0] blk_a  [N_CH];
    logic [DATA_W-1:0] norm_a [N_CH];
    logic [DATA_W-1:0] pat_a  [N_CH];
    logic [DATA_W-1:0] out_a  [N_CH];

    assign blk_a[0]  = blk_code_ev;
    assign blk_a[1]  = blk_code_od;
    assign norm_a[0] = norm_ev;
    assign norm_a[1] = norm_od;
    assign out_ev    = out_a[0];
    assign out_od    = out_a[1];

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        pgen_seq u_seq (
            .clk     (clk),
            .rst     (rst),
            .run     (test_en),
            .stb     (pix_stb),
            .sel     (pat_sel),
            .ivl     (ivl_code),
            .blk     (blk_a[ch]),
            .pat_val (pat_a[ch])
        );
        pgen_sel u_sel (
            .clk     (clk),
            .rst     (rst),
            .stb     (pix_stb),
            .test_en (test_en),
            .pat_val (pat_a[ch]),
            .norm    (norm_a[ch]),
            .out_q   (out_a[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= pix_stb;
    end

    // R2: valid follows the strobe by one cycle
    p_vld_set_r2: assert property (@(posedge clk) disable iff (rst)
        pix_stb |=> out_vld);
    p_vld_clr_r2: assert property (@(posedge clk) disable iff (rst)
        !pix_stb |=> !out_vld);

    // R1: reset state at the ports
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (out_vld == 1'b0 || rst));

endmodule

// File: tb/pgen_top_tb.sv
module pgen_top_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_stb = 1'b0;
    logic        test_en = 1'b0;
    logic        pat_sel = 1'b0;
    logic [1:0]  ivl_code = 2'd0;
    logic [7:0]  blk_code_ev = 8'd0;
    logic [7:0]  blk_code_od = 8'd0;
    logic [11:0] norm_ev = 12'd0;
    logic [11:0] norm_od = 12'd0;
    logic [11:0] out_ev, out_od;
    logic        out_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] ev;
        logic [11:0] od;
        string       req;
    } exp_t;

    exp_t q[$];

    // scoreboard model state, one entry per channel
    int m_cnt [2];
    bit m_hi  [2];
    int m_ramp[2];

    always #(CLK_P/2) clk = ~clk;

    pgen_top u_dut (
        .clk(clk), .rst(rst), .pix_stb(pix_stb), .test_en(test_en),
        .pat_sel(pat_sel), .ivl_code(ivl_code),
        .blk_code_ev(blk_code_ev), .blk_code_od(blk_code_od),
        .norm_ev(norm_ev), .norm_od(norm_od),
        .out_ev(out_ev), .out_od(out_od), .out_vld(out_vld)
    );

    function automatic void model_init();
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_hi[c] = 1'b0; m_ramp[c] = 1;
        end
    endfunction

    function automatic int model_val(int c, bit sel, logic [7:0] code);
        if (sel) return 2 * int'(code) + (m_hi[c] ? 128 : 0);
        return m_ramp[c];
    endfunction

    function automatic void model_step(int c, bit sel, logic [1:0] iv);
        int len;
        len = sel ? (8 << iv) : (2 << iv);
        m_cnt[c]++;
        if (m_cnt[c] == len) begin
            m_cnt[c] = 0;
            if (sel) m_hi[c] = ~m_hi[c];
            else     m_ramp[c] = (m_ramp[c] == 4095) ? 1 : m_ramp[c] + 1;
        end
    endfunction

    // driver: one cycle of stimulus, pushes expected words on strobes
    task automatic pix(input bit s, input bit en, input bit sel, input logic [1:0] iv,
                       input logic [7:0] ce, input logic [7:0] co,
                       input logic [11:0] ne, input logic [11:0] no, input string req);
        exp_t e;
        @(negedge clk);
        pix_stb = s; test_en = en; pat_sel = sel; ivl_code = iv;
        blk_code_ev = ce; blk_code_od = co; norm_ev = ne; norm_od = no;
        if (!en) begin
            if (s) begin
                e.ev = ne; e.od = no; e.req = req;
                q.push_back(e);
            end
            model_init();
        end else if (s) begin
            e.ev = 12'(model_val(0, sel, ce));
            e.od = 12'(model_val(1, sel, co));
            e.req = req;
            q.push_back(e);
            model_step(0, sel, iv);
            model_step(1, sel, iv);
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compares registered outputs at the falling edge
    logic [11:0] prev_ev = '0, prev_od = '0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_vld) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_ev == e.ev, {e.req, " even"}, int'(out_ev), int'(e.ev));
                    check(out_od == e.od, {e.req, " odd"},  int'(out_od), int'(e.od));
                end
            end else begin
                // R8: no strobe in the previous cycle leaves outputs untouched
                check(out_ev == prev_ev && out_od == prev_od, "R8 hold",
                      int'(out_ev), int'(prev_ev));
            end
        end
        prev_ev = out_ev;
        prev_od = out_od;
    end

    initial begin
        #(CLK_P * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_init();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_ev == 0 && out_od == 0 && out_vld == 0, "R1 reset", int'(out_ev), 0);
        @(negedge clk); rst = 1'b0;

        // R2: pass-through with gaps
        for (int i = 0; i < 24; i++)
            pix((i % 3) != 2, 1'b0, 1'b1, 2'd0, 8'd80, 8'd255,
                12'(i * 171 + 5), 12'(4090 - i * 97), "R2 passthrough");

        // R3 and R7: stripe, narrow spans, different black codes; enable on a strobe (R6)
        for (int i = 0; i < 40; i++)
            pix(1'b1, 1'b1, 1'b1, 2'd0, 8'd80, 8'd255, 12'd7, 12'd9, "R3 R7 stripe w8");

        // R3 and R8: widest stripe with strobe every other cycle
        pix(1'b0, 1'b0, 1'b1, 2'd3, 8'd3, 8'd0, 12'd0, 12'd0, "R6 restart");
        for (int i = 0; i < 280; i++)
            pix(i[0], 1'b1, 1'b1, 2'd3, 8'd3, 8'd0, 12'd1, 12'd2, "R3 R8 stripe w64");

        // R6: stop mid-span, switch to ramp, enable and strobe in the same cycle
        pix(1'b1, 1'b0, 1'b0, 2'd1, 8'd3, 8'd0, 12'd100, 12'd200, "R6 stop");
        for (int i = 0; i < 30; i++)
            pix(1'b1, 1'b1, 1'b0, 2'd1, 8'd3, 8'd0, 12'd0, 12'd0, "R4 R6 ramp s4");

        pix(1'b0, 1'b0, 1'b0, 2'd2, 8'd0, 8'd0, 12'd0, 12'd0, "R6 stop");
        for (int i = 0; i < 40; i++)
            pix(1'b1, 1'b1, 1'b0, 2'd2, 8'd0, 8'd0, 12'd0, 12'd0, "R4 ramp s8");

        // R5: full ramp with wrap at shortest spacing
        pix(1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 8'd0, 12'd0, 12'd0, "R6 stop");
        for (int i = 0; i < 8200; i++)
            pix(1'b1, 1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 12'd0, 12'd0, "R5 ramp wrap");

        // R6 and R7: back to stripe starting low, mid span code change on even only
        pix(1'b0, 1'b0, 1'b1, 2'd1, 8'd255, 8'd1, 12'd0, 12'd0, "R6 stop");
        for (int i = 0; i < 50; i++)
            pix(1'b1, 1'b1, 1'b1, 2'd1, (i < 20) ? 8'd255 : 8'd10, 8'd1,
                12'd0, 12'd0, "R6 R7 stripe w16");

        pix(1'b0, 1'b0, 1'b1, 2'd1, 8'd0, 8'd0, 12'd0, 12'd0, "idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        check(q.size() == 0, "R2 pending items", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule